// File: doc/BRIEF.md
# Interrupt Pending State Bank

This block keeps the pending state for a bank of `NUM_IRQ` interrupts. Each interrupt is set up as edge- or level-triggered by one configuration bit. Hardware drives a line per interrupt and an activation strobe per interrupt. Software reaches the bank one 32-bit word at a time through a single register port. That port has four selectable registers: set-pending, clear-pending, trigger configuration and a 32-bit status word.

A mode input (`reg_raw`) switches the port between two views.

- **Architectural view (`reg_raw=0`).** Reads return the effective pending value. The status word behaves as write-one-to-clear.
- **Raw view (`reg_raw=1`).** This view exists for saving and restoring state. Reads and writes go straight to the stored software latch and the status bits. No architectural semantics apply, so the complete internal state can be captured and loaded back.

A separate read port returns the live line levels of 32 consecutive interrupts, selected by a base ID.

Top module: `pend_bank`

## Requirements
- R1: After reset every latch bit, every configuration bit and every status bit is 0. A configuration bit of 0 means level-triggered and 1 means edge-triggered.
- R2: For an edge-triggered interrupt, a line that is high in a cycle after being low in the previous cycle sets the latch at the next clock edge. The latch stays set after the line falls. A line held high does not set it again.
- R3: Register select encodings are 0 = set-pending, 1 = clear-pending, 2 = configuration and 3 = status. An architectural write of 1 bits to set-pending sets those latch bits. For a level-triggered interrupt, the architectural read of set-pending or clear-pending returns latch OR line. For an edge-triggered interrupt it returns the latch alone.
- R4: The latch bit is cleared by either an architectural write of 1 to the clear-pending bit or an activation strobe. A level-triggered interrupt still reads as pending architecturally while its line is high.
- R5: With `reg_raw=1`, a set-pending read returns the raw latch word, and a set-pending write replaces that latch word with the written data. Clear-pending reads as zero, and writes to it are ignored.
- R6: Status bits are set by `stat_evt` pulses, limited to the bits in `STAT_MASK`. An architectural status write clears the bits written as 1 and leaves the bits written as 0 unchanged. A status read ignores `reg_word`.
- R7: A raw status write loads the written value into the `STAT_MASK` bits. Bits outside the mask always read as 0.
- R8: Bit n of `lvl_rdata` is the line of interrupt `lvl_base`+n. The whole word reads 0 when `lvl_base` is not a multiple of 32 or when it is at or above `NUM_IRQ`.
- R9: When a set-pending write and an activation reach the same bit in the same cycle, the clear wins and the latch bit ends at 0.
- R10: For select values 0 to 2, a word index at or above `NUM_IRQ`/32 reads as 0, and writes to it change no state.
- R11: The configuration word can be written and read through select 2 in either view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_IRQ | Interrupt input lines |
| irq_act | input | NUM_IRQ | Activation strobes, one cycle each |
| stat_evt | input | 32 | Status set events |
| reg_en | input | 1 | Register access enable |
| reg_we | input | 1 | Write when high, read when low |
| reg_raw | input | 1 | 1 selects the raw save/restore view |
| reg_sel | input | 2 | Register select (0 set-pending, 1 clear-pending, 2 configuration, 3 status) |
| reg_word | input | 5 | Word index (interrupts 32*word to 32*word+31) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| lvl_base | input | 10 | Base interrupt ID for the line-level bitmap |
| lvl_rdata | output | 32 | Line-level bitmap |

## Verification
The bench builds the block with `NUM_IRQ`=96 and `STAT_MASK`=0xF. With three implemented words, word index 3 and base ID 96 lie just past the bank. This makes the out-of-range read-zero and write-ignore rules observable right at the boundary. The 4-bit status mask leaves reserved bits that status events and raw writes both try to set, which exposes any leak through them. Edge and level interrupts share word 0, so clears, activations and held lines can be compared side by side on the two trigger types.

// File: rtl/pend_bank.sv
module pend_bank #(
  parameter int          NUM_IRQ   = 64,
  parameter logic [31:0] STAT_MASK = 32'h0000_000F
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_line,
  input  logic [NUM_IRQ-1:0] irq_act,
  input  logic [31:0]        stat_evt,
  input  logic               reg_en,
  input  logic               reg_we,
  input  logic               reg_raw,
  input  logic [1:0]         reg_sel,
  input  logic [4:0]         reg_word,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [9:0]         lvl_base,
  output logic [31:0]        lvl_rdata
);
  localparam int NWORDS = NUM_IRQ / 32;
  localparam logic [1:0] SEL_SET = 2'd0, SEL_CLR = 2'd1, SEL_CFG = 2'd2, SEL_STAT = 2'd3;

  logic [NUM_IRQ-1:0] latch_q, cfg_q, prev_q, latch_nx, cfg_nx, eff;
  logic [31:0]        stat_q, stat_nx;

  wire wr = reg_en & reg_we;

  assign eff = latch_q | (irq_line & ~cfg_q);

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    wire        hit    = wr & (reg_word == 5'(w));
    wire [31:0] set_m  = (hit & ~reg_raw & (reg_sel == SEL_SET)) ? reg_wdata : 32'd0;
    wire [31:0] clr_m  = (hit & ~reg_raw & (reg_sel == SEL_CLR)) ? reg_wdata : 32'd0;
    wire        load   = hit & reg_raw & (reg_sel == SEL_SET);
    wire [31:0] edge_m = irq_line[w*32 +: 32] & ~prev_q[w*32 +: 32] & cfg_q[w*32 +: 32];

    assign latch_nx[w*32 +: 32] = load ? reg_wdata :
        (latch_q[w*32 +: 32] | set_m | edge_m) & ~(clr_m | irq_act[w*32 +: 32]);
    assign cfg_nx[w*32 +: 32] = (hit & (reg_sel == SEL_CFG)) ? reg_wdata : cfg_q[w*32 +: 32];
  end

  always_comb begin
    if (wr && reg_sel == SEL_STAT && reg_raw)
      stat_nx = reg_wdata & STAT_MASK;
    else if (wr && reg_sel == SEL_STAT)
      stat_nx = (stat_q & ~reg_wdata) | (stat_evt & STAT_MASK);
    else
      stat_nx = stat_q | (stat_evt & STAT_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      cfg_q   <= '0;
      prev_q  <= '0;
      stat_q  <= '0;
    end else begin
      latch_q <= latch_nx;
      cfg_q   <= cfg_nx;
      prev_q  <= irq_line;
      stat_q  <= stat_nx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_STAT) begin
      reg_rdata = stat_q;
    end else begin
      for (int w = 0; w < NWORDS; w++) begin
        if (reg_word == 5'(w)) begin
          case (reg_sel)
            SEL_SET: reg_rdata = reg_raw ? latch_q[w*32 +: 32] : eff[w*32 +: 32];
            SEL_CLR: reg_rdata = reg_raw ? 32'd0 : eff[w*32 +: 32];
            default: reg_rdata = cfg_q[w*32 +: 32];
          endcase
        end
      end
    end
  end

  always_comb begin
    lvl_rdata = '0;
    for (int w = 0; w < NWORDS; w++)
      if (lvl_base[9:5] == 5'(w) && lvl_base[4:0] == 5'd0)
        lvl_rdata = irq_line[w*32 +: 32];
  end
endmodule

module pend_bank_chk #(
  parameter int          NUM_IRQ   = 64,
  parameter logic [31:0] STAT_MASK = 32'h0000_000F
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_line,
  input logic [NUM_IRQ-1:0] irq_act,
  input logic [31:0]        stat_evt,
  input logic               reg_en,
  input logic               reg_we,
  input logic               reg_raw,
  input logic [1:0]         reg_sel,
  input logic [4:0]         reg_word,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [9:0]         lvl_base,
  input logic [31:0]        lvl_rdata,
  input logic [NUM_IRQ-1:0] latch_q,
  input logic [NUM_IRQ-1:0] cfg_q,
  input logic [31:0]        stat_q
);
  localparam int NWORDS = NUM_IRQ / 32;

  assert_raw_clr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_raw && reg_sel == 2'd1) |-> reg_rdata == 32'd0);

  assert_word_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel != 2'd3 && int'(reg_word) >= NWORDS) |-> reg_rdata == 32'd0);

  assert_lvl_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_base[4:0] != 5'd0) |-> lvl_rdata == 32'd0);

  assert_level_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[0] && irq_line[0] && reg_sel == 2'd0 && !reg_raw && reg_word == 5'd0)
      |-> reg_rdata[0]);

  assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && !reg_raw && reg_sel == 2'd0 && reg_word == 5'd0 &&
     reg_wdata[0] && irq_act[0]) |=> !latch_q[0]);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && !reg_raw && reg_sel == 2'd3)
      |=> (stat_q & $past(reg_wdata) & ~$past(stat_evt)) == 32'd0);

  assert_stat_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> (reg_rdata & ~STAT_MASK) == 32'd0);
endmodule

bind pend_bank pend_bank_chk #(.NUM_IRQ(NUM_IRQ), .STAT_MASK(STAT_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_act(irq_act),
  .stat_evt(stat_evt), .reg_en(reg_en), .reg_we(reg_we), .reg_raw(reg_raw),
  .reg_sel(reg_sel), .reg_word(reg_word), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .lvl_base(lvl_base), .lvl_rdata(lvl_rdata),
  .latch_q(latch_q), .cfg_q(cfg_q), .stat_q(stat_q)
);

// File: tb/pend_bank_bench.sv
`timescale 1ns/1ps
module pend_bank_bench;
  localparam int N = 96;

  logic          clk = 0, rst_n = 0;
  logic [N-1:0]  irq_line = '0, irq_act = '0;
  logic [31:0]   stat_evt = '0, reg_wdata = '0, reg_rdata, lvl_rdata;
  logic          reg_en = 0, reg_we = 0, reg_raw = 0;
  logic [1:0]    reg_sel = '0;
  logic [4:0]    reg_word = '0;
  logic [9:0]    lvl_base = '0;
  int            n_chk = 0, n_err = 0;
  bit            done = 0;

  always #2 clk = ~clk;

  pend_bank #(.NUM_IRQ(N), .STAT_MASK(32'h0000_000F)) u_pend_bank (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_act(irq_act),
    .stat_evt(stat_evt), .reg_en(reg_en), .reg_we(reg_we), .reg_raw(reg_raw),
    .reg_sel(reg_sel), .reg_word(reg_word), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .lvl_base(lvl_base), .lvl_rdata(lvl_rdata));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input bit raw, input logic [1:0] sel, input logic [4:0] w, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_raw = raw; reg_sel = sel; reg_word = w; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input bit raw, input logic [1:0] sel, input logic [4:0] w, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_raw = raw; reg_sel = sel; reg_word = w;
    #1 d = reg_rdata;
    reg_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, 2'd0, 5'd0, d); check("R1 pending", d, 32'h0);
    rd(1, 2'd2, 5'd1, d); check("R1 config", d, 32'h0);
    rd(0, 2'd3, 5'd0, d); check("R1 status", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); irq_line[3] = 1;
    rd(0, 2'd0, 5'd0, d); check("R3 line only", d, 32'h8);
    rd(1, 2'd0, 5'd0, d); check("R5 raw no line", d, 32'h0);
    wr(0, 2'd0, 5'd0, 32'h20);
    rd(0, 2'd1, 5'd0, d); check("R3 latch or line", d, 32'h28);
    rd(1, 2'd0, 5'd0, d); check("R3 raw latch", d, 32'h20);
    @(negedge clk); irq_act[5] = 1;
    @(negedge clk); irq_act[5] = 0;
    rd(1, 2'd0, 5'd0, d); check("R4 activation clears", d, 32'h0);
    wr(0, 2'd0, 5'd0, 32'h40);
    @(negedge clk); irq_line[6] = 1;
    wr(0, 2'd1, 5'd0, 32'h40);
    rd(1, 2'd0, 5'd0, d); check("R4 clear latch", d, 32'h0);
    rd(0, 2'd0, 5'd0, d); check("R4 line keeps pending", d, 32'h48);
    @(negedge clk); irq_line[3] = 0; irq_line[6] = 0;
    rd(0, 2'd0, 5'd0, d); check("R3 line low", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(0, 2'd2, 5'd0, 32'h0000_0F00);
    rd(1, 2'd2, 5'd0, d); check("R11 config readback", d, 32'h0000_0F00);
    @(negedge clk); irq_line[8] = 1;
    @(negedge clk);
    rd(1, 2'd0, 5'd0, d); check("R2 edge latched", d, 32'h100);
    @(negedge clk); irq_line[8] = 0;
    rd(0, 2'd0, 5'd0, d); check("R2 held after fall", d, 32'h100);
    @(negedge clk); irq_line[8] = 1;
    @(negedge clk);
    wr(0, 2'd1, 5'd0, 32'h100);
    rd(0, 2'd0, 5'd0, d); check("R2 held line no retrigger", d, 32'h0);
    @(negedge clk); irq_line[8] = 0;
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_raw = 0; reg_sel = 2'd0; reg_word = 5'd0;
    reg_wdata = 32'h200; irq_act[9] = 1;
    @(negedge clk);
    reg_en = 0; reg_we = 0; irq_act[9] = 0;
    rd(1, 2'd0, 5'd0, d); check("R9 clear beats set", d, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] d;
    wr(1, 2'd0, 5'd1, 32'hA5A5_0000);
    rd(1, 2'd0, 5'd1, d); check("R5 raw load", d, 32'hA5A5_0000);
    wr(1, 2'd1, 5'd1, 32'hFFFF_FFFF);
    rd(1, 2'd0, 5'd1, d); check("R5 raw clear ignored", d, 32'hA5A5_0000);
    rd(1, 2'd1, 5'd1, d); check("R5 raw clear reads zero", d, 32'h0);
    @(negedge clk); irq_line[32] = 1; irq_line[40] = 1;
    rd(0, 2'd0, 5'd1, d); check("R3 arch word1", d, 32'hA5A5_0101);
    rd(1, 2'd0, 5'd1, d); check("R5 raw word1", d, 32'hA5A5_0000);
    wr(1, 2'd2, 5'd2, 32'h1);
    rd(0, 2'd2, 5'd2, d); check("R11 raw config write", d, 32'h1);
  endtask

  task automatic t_range();
    logic [31:0] d;
    wr(0, 2'd0, 5'd3, 32'hFFFF);
    rd(0, 2'd0, 5'd3, d); check("R10 word out of range", d, 32'h0);
    rd(1, 2'd0, 5'd2, d); check("R10 neighbour untouched", d, 32'h0);
    @(negedge clk); lvl_base = 10'd32;
    #1 check("R8 bitmap", lvl_rdata, 32'h101);
    @(negedge clk); lvl_base = 10'd33;
    #1 check("R8 misaligned", lvl_rdata, 32'h0);
    @(negedge clk); lvl_base = 10'd96;
    #1 check("R8 beyond count", lvl_rdata, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); stat_evt = 32'hF3;
    @(negedge clk); stat_evt = 32'h0;
    rd(0, 2'd3, 5'd7, d); check("R6 event set masked", d, 32'h3);
    wr(0, 2'd3, 5'd0, 32'h1);
    rd(0, 2'd3, 5'd0, d); check("R6 write one clears", d, 32'h2);
    wr(0, 2'd3, 5'd0, 32'h0);
    rd(0, 2'd3, 5'd0, d); check("R6 write zero no effect", d, 32'h2);
    wr(1, 2'd3, 5'd0, 32'hFFFF_FFF5);
    rd(1, 2'd3, 5'd0, d); check("R7 raw status load", d, 32'h5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_level();
    t_edge();
    t_raw();
    t_range();
    t_status();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule